// File: doc/BRIEF.md
# Pipeline Flush Cycle Requester

This controller sits beside a pipeline whose clock is generated locally and only runs when there is work. Such a clock produces an edge for each admitted input, so values already inside the pipeline would be stranded once input stops. The block closes that gap. It keeps a down-counter of outstanding drain cycles. While that counter is non-zero, it asks the clock generator for further cycles.

Three flush policies can be chosen. In the eager policy the counter is refilled with the pipeline depth on every admission. In the delayed policy the refill waits until a quiet period has passed. That period is measured in ticks of a separate free-running timer, because the local clock may be stopped. In the exclusive policy new input is held off until the drain has finished. When the pipeline admits input by sampling its ports, the block also raises a lock request so that the ports get sampled even when no input is waiting.

Top module: `fcr_flush_requester`

## Requirements
- R1: In eager mode (`flush_mode` = 2'b00, and the reserved code 2'b11 behaves the same), an accepted `admit` strobe loads the drain count with DEPTH at the next clock edge.
- R2: `need_cycle` is high exactly when the drain count is non-zero. Each `cyc_gen` pulse lowers a non-zero count by one. The count never goes below zero, and without `cyc_gen` it holds.
- R3: When an accepted admission and a `cyc_gen` pulse arrive in the same cycle, the count becomes DEPTH; the reload beats the decrement.
- R4: In delayed mode (`flush_mode` = 2'b01), `admit` clears the count and restarts the idle wait. A `tick` in the same cycle as `admit` is not counted. The count is loaded with DEPTH at the edge of the TIMEOUT_TICKS-th later tick, provided no further `admit` arrives first.
- R5: In delayed mode, each wait loads the count only once. Ticks after the load leave the count alone until the next `admit`.
- R6: In exclusive mode (`flush_mode` = 2'b10), `in_block` is high while the count is non-zero. An `admit` during that time is ignored: the count keeps draining. In the other modes `in_block` stays low.
- R7: `lock_req` is high when the count is non-zero and `in_pending` is low.
- R8: While `rst_n` is low, the count and the idle wait are cleared. After reset no cycle is requested until there is new input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_mode | input | 2 | Flush policy: 00 eager, 01 delayed, 10 exclusive, 11 eager |
| admit | input | 1 | Input item admitted into the pipeline this cycle |
| cyc_gen | input | 1 | Local clock generator produced a cycle this cycle |
| tick | input | 1 | Strobe from the free-running timer |
| in_pending | input | 1 | Valid input data is waiting at the ports |
| need_cycle | output | 1 | Request for another local clock cycle |
| lock_req | output | 1 | Request to sample the input ports with no input waiting |
| in_block | output | 1 | Hold off new input (exclusive mode) |
| drain_left | output | $clog2(DEPTH+1) | Remaining drain cycles |

## Verification
The assertions check, on every cycle, the counter's load, decrement and hold rules and the priority of the reload. They also check that a delayed-mode load can only follow a timer expiry, that an expiry disarms the wait, and that a blocked admission never raises the count. Exact wait lengths can only be shown by the bench's vector table: the uncounted tick in the admit cycle, a restart partway through the wait, and an expiry after a cancelled flush. The same applies to reserved-mode handling, the lock request against `in_pending`, and reset in the middle of a drain.

// File: rtl/fcr_pkg.sv
package fcr_pkg;

  typedef enum logic [1:0] {
    FM_EAGER   = 2'b00,
    FM_DELAYED = 2'b01,
    FM_EXCL    = 2'b10,
    FM_SPARE   = 2'b11
  } flush_mode_e;

  // Next drain count: reload beats clear, clear beats decrement, floor at zero.
  function automatic int unsigned drain_next(int unsigned cur, logic load,
                                             logic clear, logic dec,
                                             int unsigned depth);
    if (load)                 return depth;
    else if (clear)           return 0;
    else if (dec && cur != 0) return cur - 1;
    else                      return cur;
  endfunction

  // Idle wait: true when this tick is the last one of the wait.
  function automatic logic wait_done(int unsigned ticks_seen, logic armed,
                                     logic tick, int unsigned limit);
    return armed && tick && (ticks_seen == limit - 1);
  endfunction

endpackage

// File: rtl/fcr_drain_counter.sv
module fcr_drain_counter #(
  parameter int unsigned DEPTH = 6,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          clear,
  input  logic          dec,
  output logic [CW-1:0] cnt
);
  import fcr_pkg::*;

  logic [CW-1:0] cnt_d;

  always_comb cnt_d = CW'(drain_next(int'(cnt), load, clear, dec, DEPTH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

  // R1 / R3: a reload always lands on DEPTH, whatever dec does
  assert_load_depth_R1: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cnt == CW'(DEPTH));
  assert_reload_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (load && dec) |=> cnt == CW'(DEPTH));
  // R2: step of exactly one per generated cycle
  assert_step_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !clear && dec && cnt != '0) |=> cnt == $past(cnt) - 1'b1);
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !clear && (!dec || cnt == '0)) |=> $stable(cnt));
  assert_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

endmodule

// File: rtl/fcr_idle_timer.sv
module fcr_idle_timer #(
  parameter int unsigned TIMEOUT_TICKS = 16,
  localparam int unsigned TW = (TIMEOUT_TICKS > 1) ? $clog2(TIMEOUT_TICKS) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic start,
  input  logic tick,
  output logic expire,
  output logic armed
);
  import fcr_pkg::*;

  logic [TW-1:0] seen;

  always_comb expire = enable && !start &&
                       wait_done(int'(seen), armed, tick, TIMEOUT_TICKS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      seen  <= '0;
    end else if (!enable) begin
      armed <= 1'b0;
      seen  <= '0;
    end else if (start) begin
      armed <= 1'b1;
      seen  <= '0;
    end else if (expire) begin
      armed <= 1'b0;
      seen  <= '0;
    end else if (armed && tick) begin
      seen  <= seen + 1'b1;
    end
  end

  // R4: an admission restarts the wait from zero
  assert_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && start) |=> (armed && seen == '0));
  // R5: one load per wait
  assert_single_shot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !armed);
  assert_no_count_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> seen == '0);

endmodule

// File: rtl/fcr_mode_gate.sv
module fcr_mode_gate (
  input  logic [1:0] flush_mode,
  input  logic       admit,
  input  logic       in_pending,
  input  logic       cnt_nz,
  input  logic       expire,
  output logic       timed,
  output logic       load,
  output logic       clear,
  output logic       start,
  output logic       in_block,
  output logic       lock_req
);
  import fcr_pkg::*;

  flush_mode_e md;

  always_comb begin
    md       = flush_mode_e'(flush_mode);
    timed    = (md == FM_DELAYED);
    in_block = (md == FM_EXCL) && cnt_nz;
    start    = timed && admit;
    clear    = start;
    load     = timed ? expire : (admit && !in_block);
    lock_req = cnt_nz && !in_pending;
  end

endmodule

// File: rtl/fcr_flush_requester.sv
module fcr_flush_requester #(
  parameter int unsigned DEPTH         = 6,
  parameter int unsigned TIMEOUT_TICKS = 16,
  localparam int unsigned CW           = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    flush_mode,
  input  logic          admit,
  input  logic          cyc_gen,
  input  logic          tick,
  input  logic          in_pending,
  output logic          need_cycle,
  output logic          lock_req,
  output logic          in_block,
  output logic [CW-1:0] drain_left
);
  import fcr_pkg::*;

  // Named internal events for the assertions
  logic timed, load_ev, clear_ev, start_ev, expire_ev, wait_armed, cnt_nz;

  assign cnt_nz     = (drain_left != '0);
  assign need_cycle = cnt_nz;

  fcr_mode_gate u_gate (
    .flush_mode (flush_mode),
    .admit      (admit),
    .in_pending (in_pending),
    .cnt_nz     (cnt_nz),
    .expire     (expire_ev),
    .timed      (timed),
    .load       (load_ev),
    .clear      (clear_ev),
    .start      (start_ev),
    .in_block   (in_block),
    .lock_req   (lock_req)
  );

  fcr_idle_timer #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (timed),
    .start  (start_ev),
    .tick   (tick),
    .expire (expire_ev),
    .armed  (wait_armed)
  );

  fcr_drain_counter #(.DEPTH(DEPTH)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load_ev),
    .clear (clear_ev),
    .dec   (cyc_gen),
    .cnt   (drain_left)
  );

  // R4: in delayed mode a drain can only begin after the wait expires
  assert_delayed_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_mode == FM_DELAYED && $past(flush_mode) == FM_DELAYED &&
     $past(drain_left) == '0 && drain_left != '0) |-> $past(expire_ev));
  // R6: a blocked admission never raises the count
  assert_blocked_admit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_mode == FM_EXCL && in_block && admit) |=> drain_left <= $past(drain_left));
  assert_block_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_block |-> (flush_mode == FM_EXCL && need_cycle));
  // R8: reset leaves nothing to drain
  assert_reset_clear_R8: assert property (@(posedge clk)
    !rst_n |=> (drain_left == '0 && !wait_armed));

endmodule

// File: tb/fcr_flush_requester_test.sv
module fcr_flush_requester_test;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 3;
  localparam int TOUT       = 3;
  localparam int CW         = $clog2(DEPTH + 1);
  localparam int NVEC       = 36;

  // Row layout: [7:6] mode, [5] admit, [4] cyc_gen, [3] tick, [2] in_pending,
  // [1:0] expected drain count after the edge.
  localparam logic [7:0] VEC [NVEC] = '{
    8'b00_1_0_0_0_11, 8'b00_0_1_0_1_10, 8'b00_0_1_0_0_01, 8'b00_1_1_0_0_11,
    8'b00_0_1_0_0_10, 8'b00_0_1_0_1_01, 8'b00_0_1_0_0_00, 8'b00_0_1_0_0_00,
    8'b00_0_0_1_0_00, 8'b10_1_0_0_0_11, 8'b10_1_1_0_0_10, 8'b10_0_1_0_0_01,
    8'b10_0_1_0_0_00, 8'b10_1_0_0_1_11, 8'b10_0_1_0_0_10, 8'b10_0_1_0_0_01,
    8'b10_0_1_0_0_00, 8'b01_1_0_1_0_00, 8'b01_0_0_1_0_00, 8'b01_0_0_1_0_00,
    8'b01_0_1_0_0_00, 8'b01_0_0_1_0_11, 8'b01_0_1_0_0_10, 8'b01_1_0_0_0_00,
    8'b01_0_0_1_0_00, 8'b01_0_0_1_0_00, 8'b01_1_0_1_0_00, 8'b01_0_0_1_0_00,
    8'b01_0_0_1_0_00, 8'b01_0_0_1_0_11, 8'b01_0_1_0_1_10, 8'b01_0_1_0_0_01,
    8'b01_0_1_0_0_00, 8'b01_0_0_1_0_00, 8'b11_1_0_0_0_11, 8'b11_0_1_0_0_10
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    flush_mode = 2'b00;
  logic          admit = 1'b0, cyc_gen = 1'b0, tick = 1'b0, in_pending = 1'b0;
  logic          need_cycle, lock_req, in_block;
  logic [CW-1:0] drain_left;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  fcr_flush_requester #(.DEPTH(DEPTH), .TIMEOUT_TICKS(TOUT)) uut (
    .clk(clk), .rst_n(rst_n), .flush_mode(flush_mode), .admit(admit),
    .cyc_gen(cyc_gen), .tick(tick), .in_pending(in_pending),
    .need_cycle(need_cycle), .lock_req(lock_req), .in_block(in_block),
    .drain_left(drain_left)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Expected outputs derived from the count, mode and pending flag
  task automatic chk_outputs(string tag, int mode, int pend, int exp_cnt);
    chk({tag, " count"}, int'(drain_left), exp_cnt);
    chk("R2 need_cycle", int'(need_cycle), int'(exp_cnt != 0));
    chk("R6 in_block", int'(in_block), int'(mode == 2 && exp_cnt != 0));
    chk("R7 lock_req", int'(lock_req), int'(exp_cnt != 0 && pend == 0));
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    // R8: state during and right after reset
    repeat (2) @(posedge clk);
    #1 chk_outputs("R8 in reset", 0, 0, 0);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1 chk_outputs("R8 after reset", 0, 0, 0);

    for (int i = 0; i < NVEC; i++) begin
      string tag;
      int    md;
      @(negedge clk);
      md         = int'(VEC[i][7:6]);
      flush_mode = VEC[i][7:6];
      admit      = VEC[i][5];
      cyc_gen    = VEC[i][4];
      tick       = VEC[i][3];
      in_pending = VEC[i][2];
      tag = (md == 1) ? "R4 R5 delayed" : (md == 2) ? "R6 exclusive" : "R1 R2 R3 eager";
      @(posedge clk);
      #1 chk_outputs(tag, md, int'(VEC[i][2]), int'(VEC[i][1:0]));
    end

    // R8: reset in the middle of a drain (count is 2 here)
    @(negedge clk);
    admit = 1'b0; cyc_gen = 1'b0; tick = 1'b0; in_pending = 1'b0;
    rst_n = 1'b0;
    #1 chk_outputs("R8 mid-drain reset", 3, 0, 0);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1 chk_outputs("R8 quiet after reset", 3, 0, 0);

    // R5: after reset in delayed mode, ticks alone start nothing
    @(negedge clk) flush_mode = 2'b01; tick = 1'b1;
    repeat (TOUT + 2) @(posedge clk);
    #1 chk_outputs("R5 ticks without admit", 1, 0, 0);
    @(negedge clk) tick = 1'b0;

    done = 1'b1;
    summary();
    $finish;
  end

endmodule